// File: doc/BRIEF.md
# Smart-card serial status flag unit

This block keeps the status flags of an asynchronous serial channel that runs in an ISO 7816-style smart-card mode. The shifter logic reports its events to it as single-cycle strobes: a byte moved into the transmit shifter, a byte finished, a frame received, and the error line sampled low. Direct-memory-access service strobes also reach the block. The unit turns these strobes into sticky flags, which a CPU reads and acknowledges through an 8-bit register port.

A flag that software may clear goes to 0 only under two conditions. Software must first read the register and see that flag at 1, and it must then write 0 to that bit. Any write, whatever its value, discards the read qualification. The transmit-end flag is held back after each byte by a count of half elementary time units (etu): 2.5 etu in normal mode and 1.0 etu in guard mode. It is not set at all while an error signal is flagged.

Top module: `sc_status_unit`

## Requirements
- R1: After reset `reg_rdata_o` reads 8'h21, with tx-empty (bit 0) and tx-end (bit 5) at 1, and `mpb_tx_o` is 0. Bit map: 0 tx-empty, 1 rx-full, 2 overrun, 3 error-signal, 4 parity error, 5 tx-end, 6 received mpb, 7 mpb to send.
- R2: A write with bit n = 0 clears clearable flag n (bits 0..4) only if the register read just before it returned that flag as 1. Writing 1, or writing 0 without such a read, leaves the flag unchanged.
- R3: Any write, and any hardware clear of the flag, discards that flag's read qualification. A later write of 0 with no new read leaves a flag that has been set again at 1.
- R4: Tx-empty is set while `tx_en_i` is 0 and on `tdr_to_tsr_i`. It is cleared by a qualified write of 0 or by `dma_tx_wr_i`. A set in the same cycle as a clear wins.
- R5: `rx_done_i` with rx-full = 0 and correct parity sets rx-full. `dma_rx_rd_i` clears rx-full.
- R6: `rx_done_i` while rx-full = 1 sets overrun and leaves rx-full and the received mpb unchanged.
- R7: With rx-full = 0, `rx_done_i` sets the parity error flag when the number of 1s in `rx_data_i` plus `rx_parity_i` is odd with `parity_odd_i` = 0, or even with `parity_odd_i` = 1. Such a frame does not set rx-full.
- R8: `err_sig_low_i` sets the error-signal flag. `standby_i` clears it. Changes of `tx_en_i` do not affect it.
- R9: After `tx_byte_done_i`, tx-end is set at the 5th `half_etu_tick_i` (guard = 0) or at the 2nd (guard = 1). This happens only if tx-empty = 1 and error-signal = 0 at that tick.
- R10: Tx-end is read-only. It is set while `tx_en_i` = 0 and error-signal = 0. It is cleared whenever tx-empty is cleared, by a qualified write or by DMA.
- R11: A `tdr_to_tsr_i` strobe cancels a pending tx-end delay.
- R12: A frame that sets rx-full copies `rx_mpb_i` into bit 6. Every write loads bit 7, which drives `mpb_tx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby/module-stop strobe, clears error-signal |
| tx_en_i | input | 1 | Transmit enable |
| guard_mode_i | input | 1 | Guard mode, selects the 1.0 etu delay |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| tdr_to_tsr_i | input | 1 | Holding register moved into the shifter (byte start) |
| tx_byte_done_i | input | 1 | Transmit byte finished, starts the delay |
| half_etu_tick_i | input | 1 | One pulse per half etu |
| rx_done_i | input | 1 | Frame reception complete |
| rx_data_i | input | 8 | Received data |
| rx_parity_i | input | 1 | Received parity bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| err_sig_low_i | input | 1 | Error line sampled low |
| dma_tx_wr_i | input | 1 | DMA wrote the transmit holding register |
| dma_rx_rd_i | input | 1 | DMA read the receive holding register |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register read data |
| mpb_tx_o | output | 1 | Multiprocessor bit to send |

## Verification
Two functions can act on one flag in the same cycle: the qualified software clear and a hardware set event. The bench provokes this by issuing the clearing write in the same cycle as a byte-start strobe. It then checks that tx-empty stays at 1. A second conflict is between clear qualification and a re-set: a DMA clear and a new set fall between the read and the write. The bench requires that the stale write of 0 leaves the flag at 1.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned N_CLR      = 5;
  localparam int unsigned B_TXE      = 0;
  localparam int unsigned B_RXF      = 1;
  localparam int unsigned B_OVR      = 2;
  localparam int unsigned B_ERRSIG   = 3;
  localparam int unsigned B_PAR      = 4;
  localparam int unsigned B_TXDONE   = 5;
  localparam int unsigned B_MPB_RX   = 6;
  localparam int unsigned B_MPB_TX   = 7;
  localparam logic [N_CLR-1:0] CLR_RST = 5'b00001;
endpackage

// File: rtl/sc_flag_cell.sv
module sc_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o,
  output logic clr_o
);
  logic q_q, seen_q, qual_clr;

  assign qual_clr = wr_i && !wbit_i && seen_q;
  assign clr_o    = qual_clr || hw_clr_i;
  assign q_o      = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= RST_VAL;
    end else if (set_i) begin
      q_q <= 1'b1;
    end else if (clr_o) begin
      q_q <= 1'b0;
    end
  end

  // qualification: latched on read, dropped on any write or hardware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else if (wr_i || hw_clr_i) begin
      seen_q <= 1'b0;
    end else if (rd_i) begin
      seen_q <= q_q;
    end
  end

  p_wr1_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && wr_i && wbit_i && !hw_clr_i) |=> q_q);
  p_stale_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && wr_i && !seen_q && !hw_clr_i) |=> q_q);
endmodule

// File: rtl/sc_etu_delay.sv
module sc_etu_delay #(
  parameter int unsigned HALF_NORM = 5,
  parameter int unsigned HALF_GM   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  input  logic guard_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int unsigned MAXH  = (HALF_NORM > HALF_GM) ? HALF_NORM : HALF_GM;
  localparam int unsigned CNT_W = $clog2(MAXH + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q, tgt_q;
  logic             last;

  assign last   = (cnt_q == tgt_q - CNT_W'(1));
  assign fire_o = active_q && tick_i && last && !start_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= CNT_W'(HALF_NORM);
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      tgt_q    <= guard_i ? CNT_W'(HALF_GM) : CNT_W'(HALF_NORM);
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_cancel_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !start_i) |=> !active_q);
endmodule

// File: rtl/sc_status_unit.sv
module sc_status_unit
  import sc_status_pkg::*;
#(
  parameter int unsigned HALF_NORM = 5,
  parameter int unsigned HALF_GM   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             tx_en_i,
  input  logic             guard_mode_i,
  input  logic             parity_odd_i,
  input  logic             tdr_to_tsr_i,
  input  logic             tx_byte_done_i,
  input  logic             half_etu_tick_i,
  input  logic             rx_done_i,
  input  logic [REG_W-1:0] rx_data_i,
  input  logic             rx_parity_i,
  input  logic             rx_mpb_i,
  input  logic             err_sig_low_i,
  input  logic             dma_tx_wr_i,
  input  logic             dma_rx_rd_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mpb_tx_o
);
  logic [N_CLR-1:0] set_v, hwclr_v, flag_q, clr_ev;
  logic par_bad, rx_ok, fire, tend_q, tend_set, mpb_rx_q, mpb_tx_q;

  assign par_bad = (^{rx_data_i, rx_parity_i}) ^ parity_odd_i;
  assign rx_ok   = rx_done_i && !flag_q[B_RXF] && !par_bad;

  always_comb begin
    set_v             = '0;
    hwclr_v           = '0;
    set_v[B_TXE]      = !tx_en_i || tdr_to_tsr_i;
    set_v[B_RXF]      = rx_ok;
    set_v[B_OVR]      = rx_done_i && flag_q[B_RXF];
    set_v[B_ERRSIG]   = err_sig_low_i;
    set_v[B_PAR]      = rx_done_i && !flag_q[B_RXF] && par_bad;
    hwclr_v[B_TXE]    = dma_tx_wr_i;
    hwclr_v[B_RXF]    = dma_rx_rd_i;
    hwclr_v[B_ERRSIG] = standby_i;
  end

  for (genvar i = 0; i < N_CLR; i++) begin : g_flag
    sc_flag_cell #(.RST_VAL(CLR_RST[i])) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v[i]),
      .hw_clr_i(hwclr_v[i]),
      .rd_i    (reg_rd_i),
      .wr_i    (reg_wr_i),
      .wbit_i  (reg_wdata_i[i]),
      .q_o     (flag_q[i]),
      .clr_o   (clr_ev[i])
    );
  end

  sc_etu_delay #(.HALF_NORM(HALF_NORM), .HALF_GM(HALF_GM)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_byte_done_i),
    .cancel_i(tdr_to_tsr_i),
    .guard_i (guard_mode_i),
    .tick_i  (half_etu_tick_i),
    .fire_o  (fire)
  );

  assign tend_set = !flag_q[B_ERRSIG] && (!tx_en_i || (fire && flag_q[B_TXE]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q <= 1'b1;
    end else if (tend_set) begin
      tend_q <= 1'b1;
    end else if (clr_ev[B_TXE]) begin
      tend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpb_rx_q <= 1'b0;
      mpb_tx_q <= 1'b0;
    end else begin
      if (rx_ok)    mpb_rx_q <= rx_mpb_i;
      if (reg_wr_i) mpb_tx_q <= reg_wdata_i[B_MPB_TX];
    end
  end

  assign reg_rdata_o = {mpb_tx_q, mpb_rx_q, tend_q, flag_q};
  assign mpb_tx_o    = mpb_tx_q;

  p_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && flag_q[B_RXF] && !reg_wr_i && !dma_rx_rd_i)
    |=> (flag_q[B_OVR] && flag_q[B_RXF] && $stable(mpb_rx_q)));
  p_tend_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_q) |-> !$past(flag_q[B_ERRSIG]));
  p_tend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tend_q) |-> $past(clr_ev[B_TXE]));
  p_errsig_txen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[B_ERRSIG] && !standby_i && !reg_wr_i) |=> flag_q[B_ERRSIG]);
endmodule

// File: tb/sc_status_unit_bench.sv
module sc_status_unit_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic standby_i = 0, tx_en_i = 0, guard_mode_i = 0, parity_odd_i = 0;
  logic tdr_to_tsr_i = 0, tx_byte_done_i = 0, half_etu_tick_i = 0, rx_done_i = 0;
  logic [7:0] rx_data_i = '0;
  logic rx_parity_i = 0, rx_mpb_i = 0, err_sig_low_i = 0, dma_tx_wr_i = 0, dma_rx_rd_i = 0;
  logic reg_rd_i = 0, reg_wr_i = 0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic mpb_tx_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  sc_status_unit u_sc_status_unit (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd();
    @(negedge clk_i) reg_rd_i = 1;
    @(negedge clk_i) reg_rd_i = 0;
  endtask
  task automatic wr(input logic [7:0] v, input logic with_tdr = 0);
    @(negedge clk_i) begin reg_wr_i = 1; reg_wdata_i = v; tdr_to_tsr_i = with_tdr; end
    @(negedge clk_i) begin reg_wr_i = 0; tdr_to_tsr_i = 0; end
  endtask
  task automatic tdr();
    @(negedge clk_i) tdr_to_tsr_i = 1;
    @(negedge clk_i) tdr_to_tsr_i = 0;
  endtask
  task automatic done();
    @(negedge clk_i) tx_byte_done_i = 1;
    @(negedge clk_i) tx_byte_done_i = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) half_etu_tick_i = 1;
      @(negedge clk_i) half_etu_tick_i = 0;
    end
  endtask
  task automatic rx(input logic [7:0] d, input logic p, input logic m);
    @(negedge clk_i) begin rx_done_i = 1; rx_data_i = d; rx_parity_i = p; rx_mpb_i = m; end
    @(negedge clk_i) rx_done_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata_o, 8'h21);
    chk("R1 mpb_tx", {7'd0, mpb_tx_o}, 8'h00);
  endtask

  task automatic t_qualify();
    @(negedge clk_i) tx_en_i = 1;
    wr(8'h00);
    chk("R2 no read", {7'd0, reg_rdata_o[0]}, 8'h01);
    rd(); wr(8'hFF);
    chk("R2 write one", {7'd0, reg_rdata_o[0]}, 8'h01);
    chk("R12 mpb_tx", {7'd0, mpb_tx_o}, 8'h01);
    rd(); wr(8'h00);
    chk("R2 cleared", {7'd0, reg_rdata_o[0]}, 8'h00);
    chk("R10 tend follows", {7'd0, reg_rdata_o[5]}, 8'h00);
    wr(8'h20);
    chk("R10 read-only", {7'd0, reg_rdata_o[5]}, 8'h00);
  endtask

  task automatic t_stale();
    tdr();
    chk("R4 tdr sets", {7'd0, reg_rdata_o[0]}, 8'h01);
    rd();
    @(negedge clk_i) dma_tx_wr_i = 1;
    @(negedge clk_i) dma_tx_wr_i = 0;
    chk("R4 dma clears", {7'd0, reg_rdata_o[0]}, 8'h00);
    tdr(); wr(8'h00);
    chk("R3 stale write", {7'd0, reg_rdata_o[0]}, 8'h01);
    rd(); wr(8'h00, 1'b1);
    chk("R4 set wins", {7'd0, reg_rdata_o[0]}, 8'h01);
  endtask

  task automatic t_delay();
    guard_mode_i = 0;
    done(); ticks(4);
    chk("R9 normal early", {7'd0, reg_rdata_o[5]}, 8'h00);
    ticks(1);
    chk("R9 normal 2.5", {7'd0, reg_rdata_o[5]}, 8'h01);
    rd(); wr(8'h00); tdr();
    guard_mode_i = 1;
    done(); ticks(1);
    chk("R9 guard early", {7'd0, reg_rdata_o[5]}, 8'h00);
    ticks(1);
    chk("R9 guard 1.0", {7'd0, reg_rdata_o[5]}, 8'h01);
    rd(); wr(8'h00); tdr();
    guard_mode_i = 0;
    done(); ticks(2); tdr(); ticks(5);
    chk("R11 cancel", {7'd0, reg_rdata_o[5]}, 8'h00);
  endtask

  task automatic t_rx();
    parity_odd_i = 0;
    rx(8'h03, 1'b0, 1'b1);
    chk("R5 rx full", reg_rdata_o & 8'h52, 8'h42);
    @(negedge clk_i) dma_rx_rd_i = 1;
    @(negedge clk_i) dma_rx_rd_i = 0;
    chk("R5 dma read", {7'd0, reg_rdata_o[1]}, 8'h00);
    rx(8'h01, 1'b0, 1'b0);
    chk("R7 even error", reg_rdata_o & 8'h12, 8'h10);
    parity_odd_i = 1;
    rx(8'h01, 1'b0, 1'b0);
    chk("R12 mpb_rx", reg_rdata_o & 8'h42, 8'h02);
    rx(8'h01, 1'b0, 1'b1);
    chk("R6 overrun", reg_rdata_o & 8'h46, 8'h06);
    rd(); wr(8'hFB);
    chk("R2 selective", reg_rdata_o & 8'h16, 8'h12);
  endtask

  task automatic t_errsig();
    @(negedge clk_i) err_sig_low_i = 1;
    @(negedge clk_i) err_sig_low_i = 0;
    chk("R8 set", {7'd0, reg_rdata_o[3]}, 8'h01);
    @(negedge clk_i) tx_en_i = 0;
    @(negedge clk_i);
    chk("R8 tx_en keeps", {7'd0, reg_rdata_o[3]}, 8'h01);
    chk("R10 suppressed", {7'd0, reg_rdata_o[5]}, 8'h00);
    tx_en_i = 1;
    rd(); wr(8'hFE);
    chk("R2 txe clr", reg_rdata_o & 8'h09, 8'h08);
    tdr(); done(); ticks(5);
    chk("R9 suppressed", {7'd0, reg_rdata_o[5]}, 8'h00);
    @(negedge clk_i) standby_i = 1;
    @(negedge clk_i) standby_i = 0;
    chk("R8 standby", {7'd0, reg_rdata_o[3]}, 8'h00);
    @(negedge clk_i) tx_en_i = 0;
    @(negedge clk_i);
    chk("R10 tx off", reg_rdata_o & 8'h21, 8'h21);
  endtask

  bit fin = 0;
  initial begin
    #100000;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_qualify();
    t_stale();
    t_delay();
    t_rx();
    t_errsig();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule